// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the hit-detection path of a small two-way set-associative cache. Every set carries one prediction bit naming the way expected to hit next. When a request is taken, the block steers the read-data selector to the predicted way at once and compares only that way's tag in the first cycle. When that compare fails, the block probes the other way in the next cycle. The result is a fast hit, a slow hit or a miss, and the prediction bit learns from the outcome.

Lines are installed through a separate fill port that carries a whole line. A fill goes into the way that is not currently predicted, and the prediction then points at the new line. The requester sees a valid/ready request channel and a response strobe. The response carries the selected word and tells a one-cycle hit apart from a two-cycle hit and from a miss.

Top module: `waypred_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, every line is invalid, and every set predicts way 0, so the first lookup of any address reports a miss.
- R2: A request address splits as bits [3:2] word within the line, bits [9:4] set index and bits [31:10] tag. Bits [1:0] are ignored. Equal tags in different sets are separate lines.
- R3: When the predicted way holds the requested line, rsp_valid is 1 with rsp_slow 0, rsp_miss 0 and the addressed word, in the cycle right after the request is taken.
- R4: When only the non-predicted way holds the line, nothing is reported in the cycle after acceptance. In the following cycle rsp_valid is 1 with rsp_slow 1 and the addressed word.
- R5: A slow hit sets that set's prediction to the way that hit, so an immediate repeat of the access is a fast hit. A fast hit leaves the prediction unchanged.
- R6: When neither way matches, rsp_valid is 1 with rsp_miss 1 two cycles after acceptance, and the set's prediction is left unchanged.
- R7: A fill writes the line, its tag and its valid state into the way not predicted for its set, then makes that way the prediction. The line in the other way is kept.
- R8: req_ready is 0 while the second probe is pending, so no request is taken then. It is 1 in the first cycle only when that cycle is a fast hit, which allows back-to-back fast hits on consecutive cycles.
- R9: Every taken request produces exactly one rsp_valid pulse, and rsp_slow and rsp_miss are never both 1.
- R10: A fill or a prediction update on one set leaves the prediction of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request taken this cycle if valid |
| req_addr | input | 32 | Byte address of the requested word |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | 32 | Requested word (meaningful on a hit) |
| rsp_slow | output | 1 | Hit found in the second probe |
| rsp_miss | output | 1 | Neither way held the line |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | 32 | Address selecting set and tag of the line |
| fill_line | input | 128 | Line contents, word 0 in the low bits |

## Verification
The assertions assume that fills arrive only while no lookup is in flight. If a fill and a slow-hit prediction update fall in the same cycle, the fill wins, and the relation between the two would not hold. The bench issues every fill from an idle state, after the previous response has ended. It drives requests only on falling edges, and it holds a request across a cycle where ready is low, to show that the request is not lost. Addresses keep the two low byte bits at zero.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int SETS       = 64;
    localparam int WAYS       = 2;

    localparam int BOFS_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BOFS_W;
    localparam int LINE_W = LINE_WORDS * WORD_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic              way_t;

    typedef struct packed {
        tag_t                tag;
        idx_t                idx;
        wsel_t               wsel;
        logic [BOFS_W-1:0]   bofs;
    } addr_t;

    typedef enum logic [1:0] {
        LK_IDLE   = 2'd0,
        LK_FIRST  = 2'd1,
        LK_SECOND = 2'd2
    } lk_state_e;

    function automatic addr_t split_addr(input logic [ADDR_W-1:0] a);
        return addr_t'(a);
    endfunction

    function automatic word_t pick_word(input line_t l, input wsel_t w);
        return l[int'(w)*WORD_W +: WORD_W];
    endfunction

endpackage

// File: rtl/wpc_way_store.sv
module wpc_way_store
    import wpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  idx_t  widx,
    input  tag_t  wtag,
    input  line_t wline,
    input  idx_t  ridx,
    output logic  rvalid,
    output tag_t  rtag,
    output line_t rline
);
    logic [SETS-1:0] valid_q;
    tag_t            tag_q  [SETS];
    line_t           line_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[widx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[widx]  <= wtag;
            line_q[widx] <= wline;
        end
    end

    assign rvalid = valid_q[ridx];
    assign rtag   = tag_q[ridx];
    assign rline  = line_q[ridx];

endmodule

// File: rtl/wpc_pred_table.sv
module wpc_pred_table
    import wpc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  idx_t            widx,
    input  way_t            wway,
    input  idx_t            ridx,
    output way_t            rway,
    input  idx_t            fidx,
    output way_t            fway,
    output logic [SETS-1:0] bits
);
    logic [SETS-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (we) begin
            bits_q[widx] <= wway;
        end
    end

    assign rway = bits_q[ridx];
    assign fway = bits_q[fidx];
    assign bits = bits_q;

    // R5 / R7: a write lands on the addressed set with the requested way
    p_pred_write_r5: assert property (@(posedge clk) disable iff (rst)
        we |=> (bits_q[$past(widx)] == $past(wway)));

endmodule

// File: rtl/wpc_lookup_fsm.sv
module wpc_lookup_fsm
    import wpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output word_t             rsp_data,
    output logic              rsp_slow,
    output logic              rsp_miss,
    output idx_t              lk_idx,
    input  way_t              pred_way,
    input  logic [WAYS-1:0]   way_valid,
    input  tag_t              way_tag  [WAYS],
    input  line_t             way_line [WAYS],
    output logic              upd_en,
    output way_t              upd_way
);
    lk_state_e state_q, state_d;
    tag_t      cur_tag_q;
    idx_t      cur_idx_q;
    wsel_t     cur_wsel_q;
    way_t      first_way_q;

    addr_t in_addr;
    way_t  probe_way;
    logic  probe_hit;
    logic  accept;

    assign in_addr = split_addr(req_addr);

    // data selector is steered by the way choice, independent of the compare
    always_comb begin
        probe_way = (state_q == LK_SECOND) ? ~first_way_q : pred_way;
    end

    assign probe_hit = way_valid[probe_way] && (way_tag[probe_way] == cur_tag_q);
    assign rsp_data  = pick_word(way_line[probe_way], cur_wsel_q);

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_slow  = 1'b0;
        rsp_miss  = 1'b0;
        case (state_q)
            LK_IDLE: begin
                req_ready = 1'b1;
            end
            LK_FIRST: begin
                req_ready = probe_hit;
                rsp_valid = probe_hit;
            end
            LK_SECOND: begin
                rsp_valid = 1'b1;
                rsp_slow  = probe_hit;
                rsp_miss  = ~probe_hit;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        case (state_q)
            LK_IDLE:   state_d = accept ? LK_FIRST : LK_IDLE;
            LK_FIRST:  state_d = probe_hit ? (accept ? LK_FIRST : LK_IDLE) : LK_SECOND;
            LK_SECOND: state_d = LK_IDLE;
            default:   state_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= LK_IDLE;
            cur_tag_q   <= '0;
            cur_idx_q   <= '0;
            cur_wsel_q  <= '0;
            first_way_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cur_tag_q  <= in_addr.tag;
                cur_idx_q  <= in_addr.idx;
                cur_wsel_q <= in_addr.wsel;
            end
            if (state_q == LK_FIRST && !probe_hit) begin
                first_way_q <= probe_way;
            end
        end
    end

    assign lk_idx  = cur_idx_q;
    assign upd_en  = (state_q == LK_SECOND) && probe_hit;
    assign upd_way = probe_way;

    // R3: a taken request either answers fast next cycle or holds ready low
    p_fast_or_wait_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> ((rsp_valid && !rsp_slow && !rsp_miss) || (!rsp_valid && !req_ready)));

    // R4 / R6: a failed first probe resolves on the next cycle
    p_second_resolves_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == LK_FIRST && !probe_hit) |=> (rsp_valid && (rsp_slow ^ rsp_miss)));

    // R9: response kinds are exclusive
    p_kinds_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_slow && rsp_miss));

    // R8: nothing is taken while a second-cycle answer is on the port
    p_no_take_in_second_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_slow || rsp_miss)) |-> !req_ready);

endmodule

// File: rtl/waypred_cache.sv
module waypred_cache
    import wpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_slow,
    output logic              rsp_miss,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line
);
    addr_t           f_addr;
    idx_t            lk_idx;
    way_t            pred_way;
    way_t            fill_pred;
    way_t            fill_way;
    logic [SETS-1:0] pred_bits;
    logic [WAYS-1:0] w_valid;
    tag_t            w_tag  [WAYS];
    line_t           w_line [WAYS];
    logic            upd_en;
    way_t            upd_way;
    logic            pt_we;
    idx_t            pt_widx;
    way_t            pt_wway;

    assign f_addr   = split_addr(fill_addr);
    assign fill_way = ~fill_pred;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        wpc_way_store u_store (
            .clk    (clk),
            .rst    (rst),
            .we     (fill_valid && (fill_way == way_t'(g))),
            .widx   (f_addr.idx),
            .wtag   (f_addr.tag),
            .wline  (fill_line),
            .ridx   (lk_idx),
            .rvalid (w_valid[g]),
            .rtag   (w_tag[g]),
            .rline  (w_line[g])
        );
    end

    // fill takes the prediction write port over a training update
    always_comb begin
        pt_we   = fill_valid || upd_en;
        pt_widx = fill_valid ? f_addr.idx : lk_idx;
        pt_wway = fill_valid ? fill_way   : upd_way;
    end

    wpc_pred_table u_pred (
        .clk  (clk),
        .rst  (rst),
        .we   (pt_we),
        .widx (pt_widx),
        .wway (pt_wway),
        .ridx (lk_idx),
        .rway (pred_way),
        .fidx (f_addr.idx),
        .fway (fill_pred),
        .bits (pred_bits)
    );

    wpc_lookup_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_slow  (rsp_slow),
        .rsp_miss  (rsp_miss),
        .lk_idx    (lk_idx),
        .pred_way  (pred_way),
        .way_valid (w_valid),
        .way_tag   (w_tag),
        .way_line  (w_line),
        .upd_en    (upd_en),
        .upd_way   (upd_way)
    );

    // R7: a fill flips its set's prediction to the way just written
    p_fill_flips_pred_r7: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> (pred_bits[$past(f_addr.idx)] != $past(pred_bits[f_addr.idx])));

    // R6: a miss with no fill leaves the set's prediction alone
    p_miss_keeps_pred_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss && !fill_valid)
        |=> (pred_bits[$past(lk_idx)] == $past(pred_bits[lk_idx])));

    // R10: at most one set's prediction changes per cycle
    p_one_set_changes_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(pred_bits ^ $past(pred_bits)) <= 1));

endmodule

// File: tb/waypred_cache_test.sv
module waypred_cache_test;

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid;
    logic         req_ready;
    logic [31:0]  req_addr;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic         rsp_slow;
    logic         rsp_miss;
    logic         fill_valid;
    logic [31:0]  fill_addr;
    logic [127:0] fill_line;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    waypred_cache uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_slow(rsp_slow), .rsp_miss(rsp_miss),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line)
    );

    localparam int K_FAST = 0;
    localparam int K_SLOW = 1;
    localparam int K_MISS = 2;

    function automatic logic [31:0] mk(input logic [21:0] tag, input logic [5:0] set,
                                       input logic [1:0] w);
        return {tag, set, w, 2'b00};
    endfunction

    function automatic logic [127:0] line_of(input logic [31:0] seed);
        return {seed + 32'd3, seed + 32'd2, seed + 32'd1, seed};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [31:0] a, input logic [31:0] seed);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_addr  = a;
        fill_line  = line_of(seed);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic read_expect(input logic [31:0] a, input int kind,
                               input logic [31:0] exp, input string req);
        @(negedge clk);
        check(req_ready == 1'b1, {req, " ready when idle"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (kind == K_FAST) begin
            check(rsp_valid && !rsp_slow && !rsp_miss, {req, " fast flags"},
                  {61'd0, rsp_valid, rsp_slow, rsp_miss}, 64'b100);
            check(rsp_data == exp, {req, " fast data"}, 64'(rsp_data), 64'(exp));
        end else begin
            check(!rsp_valid && !req_ready, {req, " first cycle quiet"},
                  {62'd0, rsp_valid, req_ready}, 64'd0);
            @(negedge clk);
            if (kind == K_SLOW) begin
                check(rsp_valid && rsp_slow && !rsp_miss, {req, " slow flags"},
                      {61'd0, rsp_valid, rsp_slow, rsp_miss}, 64'b110);
                check(rsp_data == exp, {req, " slow data"}, 64'(rsp_data), 64'(exp));
            end else begin
                check(rsp_valid && !rsp_slow && rsp_miss, {req, " miss flags"},
                      {61'd0, rsp_valid, rsp_slow, rsp_miss}, 64'b101);
            end
        end
    endtask

    // set 5: A and B share it; tags chosen distinct
    localparam logic [21:0] TA = 22'h01234;
    localparam logic [21:0] TB = 22'h02222;
    localparam logic [21:0] TC = 22'h04444;
    localparam logic [21:0] TZ = 22'h03333;
    localparam logic [31:0] SA = 32'hA000_0000;
    localparam logic [31:0] SB = 32'hB000_0000;
    localparam logic [31:0] SC = 32'hC000_0000;
    localparam logic [31:0] SD = 32'hD000_0000;

    task automatic t_reset;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
        read_expect(mk(TA, 6'd5, 2'd0), K_MISS, 32'd0, "R1 empty cache misses");
    endtask

    task automatic t_fast;
        do_fill(mk(TA, 6'd5, 2'd0), SA);
        read_expect(mk(TA, 6'd5, 2'd2), K_FAST, SA + 32'd2, "R3 fast hit word2 (R2)");
        read_expect(mk(TA, 6'd5, 2'd0) | 32'd3, K_FAST, SA, "R2 byte bits ignored");
    endtask

    task automatic t_slow_train;
        do_fill(mk(TB, 6'd5, 2'd0), SB);
        read_expect(mk(TB, 6'd5, 2'd1), K_FAST, SB + 32'd1, "R7 fresh fill predicted");
        read_expect(mk(TA, 6'd5, 2'd3), K_SLOW, SA + 32'd3, "R4 slow hit other way");
        read_expect(mk(TA, 6'd5, 2'd0), K_FAST, SA, "R5 trained to way of slow hit");
        read_expect(mk(TA, 6'd5, 2'd1), K_FAST, SA + 32'd1, "R5 fast hit keeps prediction");
        read_expect(mk(TB, 6'd5, 2'd2), K_SLOW, SB + 32'd2, "R4 slow hit back to B");
    endtask

    task automatic t_miss_keep;
        read_expect(mk(TZ, 6'd5, 2'd0), K_MISS, 32'd0, "R6 miss both ways");
        read_expect(mk(TB, 6'd5, 2'd0), K_FAST, SB, "R6 prediction kept after miss");
    endtask

    task automatic t_fill_evicts;
        do_fill(mk(TC, 6'd5, 2'd0), SC);
        read_expect(mk(TC, 6'd5, 2'd3), K_FAST, SC + 32'd3, "R7 new line predicted");
        read_expect(mk(TB, 6'd5, 2'd1), K_SLOW, SB + 32'd1, "R7 predicted line kept");
        read_expect(mk(TA, 6'd5, 2'd0), K_MISS, 32'd0, "R7 non-predicted line replaced");
    endtask

    task automatic t_sets;
        do_fill(mk(TA, 6'd6, 2'd0), SD);
        read_expect(mk(TA, 6'd6, 2'd2), K_FAST, SD + 32'd2, "R2 same tag other set");
        read_expect(mk(TB, 6'd5, 2'd3), K_FAST, SB + 32'd3, "R10 set5 prediction untouched");
        read_expect(mk(TA, 6'd7, 2'd0), K_MISS, 32'd0, "R2 index separates lines");
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = mk(TB, 6'd5, 2'd0);
        @(negedge clk);
        check(rsp_valid && !rsp_slow && !rsp_miss, "R8 b2b first fast",
              {61'd0, rsp_valid, rsp_slow, rsp_miss}, 64'b100);
        check(req_ready == 1'b1, "R8 ready on fast hit", 64'(req_ready), 64'd1);
        req_addr = mk(TB, 6'd5, 2'd3);
        @(negedge clk);
        check(rsp_valid && !rsp_slow && rsp_data == SB + 32'd3, "R8 b2b second fast",
              64'(rsp_data), 64'(SB + 32'd3));
        req_addr = mk(TC, 6'd5, 2'd1);
        @(negedge clk);
        check(!rsp_valid && !req_ready, "R8 ready low on way miss",
              {62'd0, rsp_valid, req_ready}, 64'd0);
        req_addr = mk(TB, 6'd5, 2'd2);
        @(negedge clk);
        check(rsp_valid && rsp_slow && rsp_data == SC + 32'd1, "R4 slow hit in stream",
              64'(rsp_data), 64'(SC + 32'd1));
        check(req_ready == 1'b0, "R8 ready low in second probe", 64'(req_ready), 64'd1 - 64'd1);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R9 held request not taken in second probe",
              {62'd0, rsp_valid, req_ready}, 64'b01);
        @(negedge clk);
        req_valid = 1'b0;
        check(!rsp_valid && !req_ready, "R5 B now on other way",
              {62'd0, rsp_valid, req_ready}, 64'd0);
        @(negedge clk);
        check(rsp_valid && rsp_slow && !rsp_miss && rsp_data == SB + 32'd2,
              "R9 single slow answer", 64'(rsp_data), 64'(SB + 32'd2));
        @(negedge clk);
        check(!rsp_valid, "R9 one pulse per request", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_addr   = '0;
        fill_valid = 1'b0;
        fill_addr  = '0;
        fill_line  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fast();
        t_slow_train();
        t_miss_keep();
        t_fill_evicts();
        t_sets();
        t_back_to_back();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule